// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns an asynchronous, active-low interrupt line into a clean interrupt-take request for a small 8-bit processor core. A falling edge on the line, seen after a multi-stage synchronizer, sets a request latch. The latch holds the request after the line has gone high again. The latch is judged only when the core reports an instruction boundary. It produces a take request only if the core's interrupt mask is clear.

The core acknowledges a take by pulsing a vector-fetch strobe. That strobe clears the latch, so a new pulse on the line can be captured while the service routine runs. Such a request is then served as soon as the mask drops again. A mode input picks between two sensitivities:

- Edge-only: only falling edges set the latch.
- Edge-plus-level: a line still held low, for example by several open-drain sources sharing it, keeps setting the latch after each service.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, `pending_o` is 0 and `take_o` stays 0 while the line is high. The synchronizer and edge history reset to the high (idle) level, so releasing reset never creates a request.
- R2: A high-to-low change of the line sets `pending_o`. The change is seen after SYNC_STAGES synchronizer clocks plus one latch clock. `pending_o` stays 1 after the line returns high, until a vector fetch.
- R3: `take_o` is 1 only in a cycle where `boundary_i` is 1, `mask_i` is 0 and `pending_o` is 1. It is a single-cycle pulse.
- R4: While `mask_i` is 1, `take_o` stays 0 and a set `pending_o` is kept.
- R5: A cycle with `vfetch_i` = 1 clears `pending_o` on the next edge. If a set condition occurs in that same cycle, the set wins and `pending_o` stays 1.
- R6: A pulse that arrives during the service routine, after the vector fetch, is latched. It is taken at the first boundary after `mask_i` returns to 0.
- R7: With `level_mode_i` = 1 (edge-plus-level), every cycle in which the synchronized line is low sets the latch. A line held low therefore produces repeated takes across several services.
- R8: With `level_mode_i` = 0 (edge-only), a line held low for many services produces exactly one take.
- R9: Single pulses spaced by the service length plus 19 cycles are each taken exactly once.
- R10: After a take, no further take is issued until `vfetch_i` has been seen, even if `boundary_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_int_n | input | 1 | Asynchronous active-low interrupt line |
| level_mode_i | input | 1 | 1 = edge-plus-level, 0 = edge-only |
| mask_i | input | 1 | Core interrupt mask; 1 blocks takes |
| boundary_i | input | 1 | Instruction boundary strobe |
| vfetch_i | input | 1 | Vector-fetch strobe; clears the request latch |
| take_o | output | 1 | Interrupt-take request pulse |
| pending_o | output | 1 | Request latch state |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. This makes the generate-built synchronizer chain deeper than its minimum. It also means the reference model's delay line must match a non-default latency on every cycle. A stub core with a 12-cycle service routine and a boundary every third cycle brings within reach several cases: the vector-fetch clear racing a level set, pulses landing mid-service, pulses at exactly the minimum service spacing, and a boundary held high while the fetch is withheld.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic {
        SENSE_EDGE       = 1'b0,
        SENSE_EDGE_LEVEL = 1'b1
    } sense_mode_e;

    typedef struct packed {
        logic fall;   // synchronized line went high -> low this cycle
        logic low;    // synchronized line currently low
    } line_event_t;

    typedef struct packed {
        logic boundary;
        logic mask;
        logic vfetch;
    } cpu_ctl_t;

    function automatic logic set_request(line_event_t ev, sense_mode_e mode);
        logic lvl;
        lvl = (mode == SENSE_EDGE_LEVEL) && ev.low;
        return ev.fall || lvl;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[LAST];

    AST_SYNC_IDLE_AFTER_RESET: assert property (@(posedge clk) rst |=> sync_o); // R1
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge
    import eirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        line_i,
    output line_event_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line_i;
    end

    always_comb begin
        ev_o.fall = prev_q & ~line_i;
        ev_o.low  = ~line_i;
    end

    AST_FALL_ONLY_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ev_o.fall |-> $past(line_i)); // R2
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pending_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)        pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;   // set wins over a same-cycle clear
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pending_o = pend_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pending_o); // R5
    AST_CLEAR_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pending_o); // R5
    AST_HOLD_WITHOUT_FETCH: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !clr_i) |=> pending_o); // R2
endmodule

// File: rtl/eirq_take.sv
module eirq_take
    import eirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pending_i,
    input  cpu_ctl_t ctl_i,
    output logic     take_o
);
    logic await_fetch_q;
    logic take_c;

    always_comb begin
        take_c = ctl_i.boundary && !ctl_i.mask && pending_i && !await_fetch_q;
    end

    always_ff @(posedge clk) begin
        if (rst)               await_fetch_q <= 1'b0;
        else if (ctl_i.vfetch) await_fetch_q <= 1'b0;
        else if (take_c)       await_fetch_q <= 1'b1;
    end

    assign take_o = take_c;

    AST_TAKE_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !ctl_i.mask); // R4
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ctl_i.boundary); // R3
    AST_TAKE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o); // R10
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_int_n,
    input  logic level_mode_i,
    input  logic mask_i,
    input  logic boundary_i,
    input  logic vfetch_i,
    output logic take_o,
    output logic pending_o
);
    logic        line_sync;
    line_event_t ev;
    sense_mode_e mode;
    cpu_ctl_t    ctl;
    logic        set_req;

    assign mode = level_mode_i ? SENSE_EDGE_LEVEL : SENSE_EDGE;

    always_comb begin
        ctl.boundary = boundary_i;
        ctl.mask     = mask_i;
        ctl.vfetch   = vfetch_i;
        set_req      = set_request(ev, mode);
    end

    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_int_n),
        .sync_o  (line_sync)
    );

    eirq_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_sync),
        .ev_o   (ev)
    );

    eirq_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_req),
        .clr_i     (vfetch_i),
        .pending_o (pending_o)
    );

    eirq_take u_take (
        .clk       (clk),
        .rst       (rst),
        .pending_i (pending_o),
        .ctl_i     (ctl),
        .take_o    (take_o)
    );

    AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        take_o |-> pending_o); // R3
    AST_EDGE_MODE_NO_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
        (!level_mode_i && !pending_o && line_sync) |=> !pending_o); // R8
endmodule

// File: tb/eirq_ctrl_tb.sv
`timescale 1ns/1ps
module eirq_ctrl_tb;
    localparam int STAGES  = 3;
    localparam int SVC     = 12;
    localparam int SPACING = SVC + 19;

    logic clk = 1'b0, rst = 1'b1, pin = 1'b1, lvl = 1'b0;
    logic mask = 1'b0, bnd = 1'b0, vf = 1'b0;
    logic take, pend;

    int checks = 0, errors = 0, cyc = 0, takes = 0, svc_left = 0, bnd_div = 3, t0 = 0;
    bit force_mask = 0, took_last = 0, stall = 0, kick = 0, vf_prev = 0, done = 0;
    string phase = "R1";

    logic m_sq[$];
    logic m_prev, m_pend, m_busy;

    eirq_ctrl #(.SYNC_STAGES(STAGES)) u_dut (
        .clk(clk), .rst(rst), .ext_int_n(pin), .level_mode_i(lvl),
        .mask_i(mask), .boundary_i(bnd), .vfetch_i(vf),
        .take_o(take), .pending_o(pend)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    always @(posedge clk) begin
        logic sy, fl, st, tk;
        if (rst) begin
            m_sq.delete();
            for (int i = 0; i < STAGES; i++) m_sq.push_back(1'b1);
            m_prev = 1'b1; m_pend = 1'b0; m_busy = 1'b0;
        end else begin
            sy = m_sq[STAGES-1];
            fl = m_prev && !sy;
            st = fl || (lvl && !sy);
            tk = bnd && !mask && m_pend && !m_busy;
            if (vf) m_busy = 1'b0; else if (tk) m_busy = 1'b1;
            if (st) m_pend = 1'b1; else if (vf) m_pend = 1'b0;
            m_prev = sy;
            m_sq.push_front(pin);
            void'(m_sq.pop_back());
        end
    end

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_int(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive core stub, compare against model, wait for next negedge
    task automatic step();
        logic exp_take;
        vf = (took_last && !stall) || kick;
        vf_prev = vf;
        kick = 0;
        if (took_last && !stall) svc_left = SVC;
        else if (svc_left > 0) svc_left--;
        mask = force_mask || (svc_left > 0);
        bnd = ((cyc % bnd_div) == 0);
        #1;
        exp_take = rst ? 1'b0 : (bnd && !mask && m_pend && !m_busy);
        check(phase, take, exp_take, "take_o");
        check(phase, pend, rst ? 1'b0 : m_pend, "pending_o");
        took_last = take;
        if (take) takes++;
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse(int len);
        pin = 1'b0; run(len); pin = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        run(3);
        rst = 1'b0;
        // R1: no request out of reset
        phase = "R1"; run(10);
        check("R1", pend, 1'b0, "pending after reset");
        check_int("R1", takes, 0, "takes after reset");

        // R2 / R3: single pulse latched and taken once
        phase = "R2"; t0 = takes; pulse(2);
        run(STAGES + 1);
        run(30);
        check_int("R2", takes - t0, 1, "takes for one pulse");

        // R5: fetch clears latch when line is idle
        phase = "R5"; t0 = takes; pulse(1);
        while (!took_last) step();
        step();
        check("R5", pend, 1'b0, "pending after fetch");
        run(20);

        // R4: mask blocks take, keeps latch
        phase = "R4"; force_mask = 1; t0 = takes; pulse(1); run(20);
        check("R4", pend, 1'b1, "pending held under mask");
        check_int("R4", takes - t0, 0, "takes under mask");
        force_mask = 0; run(10);
        check_int("R4", takes - t0, 1, "take after unmask");
        run(20);

        // R6: pulse during service routine
        phase = "R6"; t0 = takes; pulse(1);
        while (!took_last) step();
        run(3);
        pulse(1);
        run(50);
        check_int("R6", takes - t0, 2, "takes with mid-service pulse");

        // R9: minimum spacing
        phase = "R9"; t0 = takes;
        for (int p = 0; p < 4; p++) begin pulse(1); run(SPACING - 1); end
        run(10);
        check_int("R9", takes - t0, 4, "takes for spaced pulses");

        // R8: edge-only, held low
        phase = "R8"; lvl = 0; t0 = takes; pin = 1'b0; run(80); pin = 1'b1; run(20);
        check_int("R8", takes - t0, 1, "edge mode held-low takes");

        // R7: edge-plus-level, held low; R5 set wins over fetch
        phase = "R7"; lvl = 1; t0 = takes; pin = 1'b0;
        for (int i = 0; i < 80; i++) begin
            step();
            if (vf_prev && i > STAGES + 2) check("R5", pend, 1'b1, "set wins over fetch");
        end
        check("R7", (takes - t0) >= 2, 1'b1, "level mode repeats");
        pin = 1'b1; run(30); t0 = takes; run(30);
        check_int("R7", takes - t0, 0, "no takes after release");
        lvl = 0;

        // R10: boundary every cycle, fetch withheld
        phase = "R10"; stall = 1; bnd_div = 1; t0 = takes; pulse(1); run(20);
        check_int("R10", takes - t0, 1, "single take while awaiting fetch");
        kick = 1; step(); stall = 0; bnd_div = 3; run(10);
        check("R10", pend, 1'b0, "pending after late fetch");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule